// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one pulse-width modulation channel built around a 16-bit period counter. The counter advances on a tick that comes from one of eleven power-of-two taps of the peripheral clock, or from one of two divider outputs whose factors are programmable. The channel output is high while the counter is below a duty value. In edge mode the counter counts up and wraps. In symmetric mode it counts up to the period and then back down, so one output cycle takes twice as many ticks.

The period is not written directly. A write goes into a shadow register. The running period takes the shadow value only when the current output cycle ends. A period change therefore never produces a truncated or stretched cycle. Two write-protect inputs, one driven by software and one by hardware, can each block the shadow write. The update register has a read port, and that port always reads zero.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: A write to the update register changes only the shadow period. The active period takes the shadow value only at the end of an output cycle: in edge mode when the counter wraps to zero, and in symmetric mode when the counter comes back down to zero. The cycle that is running at the time of the write completes with the old period.
- R2: Only bits [15:0] of `upd_wdata` are used as the period. Bits [31:16] have no effect.
- R3: `upd_rdata` reads as zero at all times.
- R4: A write is dropped while `wp_sw` or `wp_hw` is high. The active period then stays unchanged.
- R5: `clk_sel` values 0 to 10 give a tick every 2^`clk_sel` clock cycles.
- R6: `clk_sel` value 11 takes ticks from divider A and value 12 takes ticks from divider B. A factor N from 1 to 255 gives one tick every N clocks. A factor of 0 gives no ticks.
- R7: `clk_sel` values 13 to 15 stop the counter, so the output holds its level.
- R8: In edge mode (`center_mode`=0), with period P and tick divisor D, the output repeats every P·D clocks. In each repeat the output is high for `duty`·D clocks.
- R9: In symmetric mode (`center_mode`=1), the output repeats every 2·P·D clocks.
- R10: A `duty` of 0 holds the output low. A `duty` equal to or greater than the active period holds the output high, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset. Sets the active period, the shadow and the counter to zero |
| clk_sel | input | 4 | Tick source: 0-10 select a prescaler tap, 11 selects divider A, 12 selects divider B, 13-15 stop the counter |
| div_a_factor | input | 8 | Factor of divider A (0 turns the divider off) |
| div_b_factor | input | 8 | Factor of divider B (0 turns the divider off) |
| center_mode | input | 1 | 0 selects edge mode, 1 selects symmetric up/down mode |
| duty | input | 16 | Compare value. The output is high while the counter is below it |
| upd_wr | input | 1 | Write strobe for the period update register |
| upd_wdata | input | 32 | Write data. Only bits [15:0] are used |
| upd_rdata | output | 32 | Read value of the update register, always zero |
| wp_sw | input | 1 | Software write-protect flag |
| wp_hw | input | 1 | Hardware write-protect flag |
| pwm_out | output | 1 | Channel output |

## Verification
The bench builds the channel with its default parameters: a 16-bit counter, 8-bit divider factors and eleven taps. With these values the slowest tap (divide by 1024) and both dividers can be run over full output cycles within the cycle budget. It measures the spacing between rising edges and the length of each high phase, and compares them with P·D and 2·P·D for random taps, divider factors, periods and duties. Directed cases cover the following: a period change in mid-cycle, write-protected writes, high-half data bits, duty at zero and at or above the period (including the top of the symmetric count), the stop codes, and a divider set to factor zero.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CNT_W    = 16;
    localparam int SEL_W    = 4;
    localparam int DIV_W    = 8;
    localparam int NUM_TAPS = 11;
    localparam int WDATA_W  = 32;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;

    typedef struct packed {
        logic tick;
        logic wrap;
    } cnt_evt_t;

    function automatic int sel_div_a(input int taps);
        return taps;
    endfunction

    function automatic int sel_div_b(input int taps);
        return taps + 1;
    endfunction

endpackage

// File: rtl/pwm_divider.sv
module pwm_divider #(
    parameter int W = pwm_pkg::DIV_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] factor,
    output logic         pulse
);
    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (factor != '0) && (cnt_q >= factor - W'(1));
    assign pulse  = at_end;

    always_ff @(posedge clk) begin
        if (rst || factor == '0) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + W'(1);
        end
    end
endmodule

// File: rtl/pwm_clk_sel.sv
module pwm_clk_sel #(
    parameter int SEL_W    = pwm_pkg::SEL_W,
    parameter int DIV_W    = pwm_pkg::DIV_W,
    parameter int NUM_TAPS = pwm_pkg::NUM_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] fac_a,
    input  logic [DIV_W-1:0] fac_b,
    output logic             tick
);
    localparam int PW    = (NUM_TAPS > 1) ? NUM_TAPS - 1 : 1;
    localparam int SEL_A = pwm_pkg::sel_div_a(NUM_TAPS);
    localparam int SEL_B = pwm_pkg::sel_div_b(NUM_TAPS);

    logic [PW-1:0]       pre_q;
    logic [NUM_TAPS-1:0] tap_en;
    logic [1:0]          div_en;
    logic [DIV_W-1:0]    fac [2];

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + PW'(1);
    end

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        if (k == 0) begin : g_first
            assign tap_en[k] = 1'b1;
        end else begin : g_rest
            assign tap_en[k] = &pre_q[k-1:0];
        end
    end

    assign fac[0] = fac_a;
    assign fac[1] = fac_b;

    for (genvar d = 0; d < 2; d++) begin : g_div
        pwm_divider #(.W(DIV_W)) u_div (
            .clk    (clk),
            .rst    (rst),
            .factor (fac[d]),
            .pulse  (div_en[d])
        );
    end

    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            if (sel == SEL_W'(k)) tick = tap_en[k];
        end
        if (sel == SEL_W'(SEL_A)) tick = div_en[0];
        if (sel == SEL_W'(SEL_B)) tick = div_en[1];
    end
endmodule

// File: rtl/pwm_period_shadow.sv
module pwm_period_shadow #(
    parameter int CW = pwm_pkg::CNT_W,
    parameter int DW = pwm_pkg::WDATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          wp_sw,
    input  logic          wp_hw,
    input  logic          boundary,
    output logic [CW-1:0] per_active,
    output logic [CW-1:0] per_shadow
);
    logic accept;
    logic pending_q;

    assign accept = wr && !wp_sw && !wp_hw;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_active <= '0;
            per_shadow <= '0;
            pending_q  <= 1'b0;
        end else begin
            if (boundary && pending_q) begin
                per_active <= per_shadow;
                pending_q  <= 1'b0;
            end
            if (accept) begin
                per_shadow <= wdata[CW-1:0];
                pending_q  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CW = pwm_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              center,
    input  logic [CW-1:0]     per,
    output logic [CW-1:0]     cnt,
    output pwm_pkg::cnt_evt_t evt
);
    import pwm_pkg::*;

    cnt_dir_e      dir_q, dir_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wrap;

    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        wrap  = 1'b0;
        if (tick) begin
            if (per == '0) begin
                cnt_d = '0;
                dir_d = DIR_UP;
                wrap  = 1'b1;
            end else if (!center) begin
                dir_d = DIR_UP;
                if (cnt_q >= per - CW'(1)) begin
                    cnt_d = '0;
                    wrap  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end else if (dir_q == DIR_UP) begin
                if (cnt_q >= per - CW'(1)) begin
                    cnt_d = per;
                    dir_d = DIR_DOWN;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end else begin
                if (cnt_q <= CW'(1)) begin
                    cnt_d = '0;
                    dir_d = DIR_UP;
                    wrap  = 1'b1;
                end else begin
                    cnt_d = cnt_q - CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_UP;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign cnt      = cnt_q;
    assign evt.tick = tick;
    assign evt.wrap = wrap;
endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel #(
    parameter int CNT_W    = pwm_pkg::CNT_W,
    parameter int SEL_W    = pwm_pkg::SEL_W,
    parameter int DIV_W    = pwm_pkg::DIV_W,
    parameter int NUM_TAPS = pwm_pkg::NUM_TAPS,
    parameter int WDATA_W  = pwm_pkg::WDATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   clk_sel,
    input  logic [DIV_W-1:0]   div_a_factor,
    input  logic [DIV_W-1:0]   div_b_factor,
    input  logic               center_mode,
    input  logic [CNT_W-1:0]   duty,
    input  logic               upd_wr,
    input  logic [WDATA_W-1:0] upd_wdata,
    output logic [WDATA_W-1:0] upd_rdata,
    input  logic               wp_sw,
    input  logic               wp_hw,
    output logic               pwm_out
);
    logic              tick;
    logic [CNT_W-1:0]  cnt_val;
    logic [CNT_W-1:0]  per_active;
    logic [CNT_W-1:0]  per_shadow;
    pwm_pkg::cnt_evt_t evt;

    pwm_clk_sel #(
        .SEL_W(SEL_W), .DIV_W(DIV_W), .NUM_TAPS(NUM_TAPS)
    ) u_clk_sel (
        .clk   (clk),
        .rst   (rst),
        .sel   (clk_sel),
        .fac_a (div_a_factor),
        .fac_b (div_b_factor),
        .tick  (tick)
    );

    pwm_counter #(.CW(CNT_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .center (center_mode),
        .per    (per_active),
        .cnt    (cnt_val),
        .evt    (evt)
    );

    pwm_period_shadow #(.CW(CNT_W), .DW(WDATA_W)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .wr         (upd_wr),
        .wdata      (upd_wdata),
        .wp_sw      (wp_sw),
        .wp_hw      (wp_hw),
        .boundary   (evt.wrap),
        .per_active (per_active),
        .per_shadow (per_shadow)
    );

    assign upd_rdata = '0;
    assign pwm_out   = (duty != '0) && ((duty >= per_active) || (cnt_val < duty));
endmodule

// File: rtl/pwm_dbuf_channel_chk.sv
module pwm_dbuf_channel_chk #(
    parameter int CNT_W    = pwm_pkg::CNT_W,
    parameter int SEL_W    = pwm_pkg::SEL_W,
    parameter int DIV_W    = pwm_pkg::DIV_W,
    parameter int NUM_TAPS = pwm_pkg::NUM_TAPS
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] clk_sel,
    input logic [DIV_W-1:0] div_a_factor,
    input logic [DIV_W-1:0] div_b_factor,
    input logic [CNT_W-1:0] duty,
    input logic             upd_wr,
    input logic             wp_sw,
    input logic             wp_hw,
    input logic             pwm_out,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] per_active,
    input logic [CNT_W-1:0] per_shadow
);
    localparam int SEL_A = pwm_pkg::sel_div_a(NUM_TAPS);
    localparam int SEL_B = pwm_pkg::sel_div_b(NUM_TAPS);

    // R1
    swap_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (per_active != $past(per_active)) |-> (cnt_val == '0));

    // R4
    protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_wr && (wp_sw || wp_hw)) |=> $stable(per_shadow));

    // R6
    div_off_chk: assert property (@(posedge clk) disable iff (rst)
        ((clk_sel == SEL_W'(SEL_A) && div_a_factor == '0) ||
         (clk_sel == SEL_W'(SEL_B) && div_b_factor == '0)) |-> !tick);

    // R7
    stop_code_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_sel > SEL_W'(SEL_B)) |=> $stable(cnt_val));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_val <= per_active);

    // R10
    duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !pwm_out);
endmodule

bind pwm_dbuf_channel pwm_dbuf_channel_chk #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .DIV_W(DIV_W), .NUM_TAPS(NUM_TAPS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clk_sel      (clk_sel),
    .div_a_factor (div_a_factor),
    .div_b_factor (div_b_factor),
    .duty         (duty),
    .upd_wr       (upd_wr),
    .wp_sw        (wp_sw),
    .wp_hw        (wp_hw),
    .pwm_out      (pwm_out),
    .tick         (tick),
    .cnt_val      (cnt_val),
    .per_active   (per_active),
    .per_shadow   (per_shadow)
);

// File: tb/pwm_dbuf_channel_tb.sv
module pwm_dbuf_channel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  clk_sel = '0;
    logic [7:0]  div_a_factor = '0;
    logic [7:0]  div_b_factor = '0;
    logic        center_mode = 1'b0;
    logic [15:0] duty = '0;
    logic        upd_wr = 1'b0;
    logic [31:0] upd_wdata = '0;
    logic [31:0] upd_rdata;
    logic        wp_sw = 1'b0;
    logic        wp_hw = 1'b0;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_dbuf_channel u_dut (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .div_a_factor(div_a_factor),
        .div_b_factor(div_b_factor), .center_mode(center_mode), .duty(duty),
        .upd_wr(upd_wr), .upd_wdata(upd_wdata), .upd_rdata(upd_rdata),
        .wp_sw(wp_sw), .wp_hw(wp_hw), .pwm_out(pwm_out)
    );

    function automatic int divisor(input int sel, input int fa, input int fb);
        if (sel <= 10) return 1 << sel;
        if (sel == 11) return fa;
        return fb;
    endfunction

    function automatic int exp_period(input int sel, input int fa, input int fb,
                                      input bit ctr, input int p);
        return p * divisor(sel, fa, fb) * (ctr ? 2 : 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edge_wait(input bit rising, output int t);
        logic prev;
        prev = pwm_out;
        t = -1;
        for (int g = 0; g < 40000; g++) begin
            @(negedge clk);
            if (rising && pwm_out && !prev) begin t = cyc; return; end
            if (!rising && !pwm_out && prev) begin t = cyc; return; end
            prev = pwm_out;
        end
    endtask

    task automatic write_period(input logic [31:0] v);
        @(negedge clk);
        upd_wr = 1'b1;
        upd_wdata = v;
        @(negedge clk);
        upd_wr = 1'b0;
    endtask

    task automatic settle_and_period(output int iv, output int hi);
        int t0, tf, t1, tx;
        edge_wait(1'b1, tx);
        edge_wait(1'b1, tx);
        edge_wait(1'b1, t0);
        edge_wait(1'b0, tf);
        edge_wait(1'b1, t1);
        iv = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
        hi = (t0 < 0 || tf < 0) ? -1 : tf - t0;
    endtask

    task automatic count_toggles(input int n, output int toggles, output int level);
        logic prev;
        @(negedge clk);
        prev = pwm_out;
        toggles = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out != prev) toggles++;
            prev = pwm_out;
        end
        level = int'(pwm_out);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d cycles expected=completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int iv, hi, p, d, s, fa, fb, tg, lv, r0, r1, r2;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 / R10: reset state
        chk("R3 rdata zero after reset", int'(upd_rdata), 0);
        chk("R10 output low after reset (duty 0)", int'(pwm_out), 0);

        // R5 / R8: random prescaler taps in edge mode
        for (int it = 0; it < 8; it++) begin
            s = $urandom % 5;
            p = 4 + $urandom % 27;
            d = 1 + $urandom % (p - 1);
            clk_sel = 4'(s); center_mode = 1'b0; duty = 16'(d);
            write_period(32'(p));
            settle_and_period(iv, hi);
            chk("R5 R8 edge-mode tap period", iv, exp_period(s, 0, 0, 0, p));
            chk("R8 edge-mode high time", hi, d * divisor(s, 0, 0));
        end

        // R5: slowest tap
        clk_sel = 4'd10; duty = 16'd1;
        write_period(32'd3);
        settle_and_period(iv, hi);
        chk("R5 tap 10 period", iv, 3 * 1024);

        // R6: dividers A and B
        for (int it = 0; it < 6; it++) begin
            s = 11 + (it % 2);
            fa = 1 + $urandom % 12;
            fb = 1 + $urandom % 12;
            p = 3 + $urandom % 18;
            d = 1 + $urandom % (p - 1);
            div_a_factor = 8'(fa); div_b_factor = 8'(fb);
            clk_sel = 4'(s); duty = 16'(d);
            write_period(32'(p));
            settle_and_period(iv, hi);
            chk("R6 divider period", iv, exp_period(s, fa, fb, 0, p));
        end

        // R9: symmetric mode
        for (int it = 0; it < 5; it++) begin
            s = $urandom % 3;
            p = 3 + $urandom % 18;
            d = 1 + $urandom % (p - 1);
            clk_sel = 4'(s); center_mode = 1'b1; duty = 16'(d);
            write_period(32'(p));
            settle_and_period(iv, hi);
            chk("R9 symmetric period", iv, exp_period(s, 0, 0, 1, p));
        end

        // R1: mid-cycle change finishes the running cycle with the old period
        center_mode = 1'b0; clk_sel = 4'd0; duty = 16'd2;
        write_period(32'd40);
        settle_and_period(iv, hi);
        chk("R1 old period established", iv, 40);
        edge_wait(1'b1, r0);
        upd_wr = 1'b1; upd_wdata = 32'd15;
        @(negedge clk);
        upd_wr = 1'b0;
        edge_wait(1'b1, r1);
        edge_wait(1'b1, r2);
        chk("R1 running cycle keeps old period", r1 - r0, 40);
        chk("R1 new period from next cycle", r2 - r1, 15);

        // R2: upper data bits ignored
        write_period(32'hABCD_000C);
        settle_and_period(iv, hi);
        chk("R2 high half ignored", iv, 12);

        // R4: write protection
        wp_sw = 1'b1;
        write_period(32'd25);
        wp_sw = 1'b0;
        settle_and_period(iv, hi);
        chk("R4 software protect drops write", iv, 12);
        wp_hw = 1'b1;
        write_period(32'd25);
        wp_hw = 1'b0;
        settle_and_period(iv, hi);
        chk("R4 hardware protect drops write", iv, 12);
        write_period(32'd25);
        settle_and_period(iv, hi);
        chk("R4 write accepted once unprotected", iv, 25);

        // R10: duty extremes (period now 25)
        duty = 16'd0;
        count_toggles(120, tg, lv);
        chk("R10 duty 0 toggles", tg, 0);
        chk("R10 duty 0 level", lv, 0);
        duty = 16'd25;
        count_toggles(120, tg, lv);
        chk("R10 duty = period toggles", tg, 0);
        chk("R10 duty = period level", lv, 1);
        duty = 16'd300;
        count_toggles(120, tg, lv);
        chk("R10 duty > period level", lv + tg, 1);
        center_mode = 1'b1; duty = 16'd25;
        count_toggles(200, tg, lv);
        chk("R10 symmetric duty = period toggles", tg, 0);
        chk("R10 symmetric duty = period level", lv, 1);

        // R7: stop codes hold the output
        center_mode = 1'b0; duty = 16'd10; clk_sel = 4'd0;
        repeat (7) @(negedge clk);
        for (int c = 13; c <= 15; c++) begin
            clk_sel = 4'(c);
            count_toggles(200, tg, lv);
            chk("R7 stop code holds output", tg, 0);
        end

        // R6: divider factor zero
        clk_sel = 4'd11; div_a_factor = 8'd0;
        count_toggles(200, tg, lv);
        chk("R6 divider factor 0 no ticks", tg, 0);

        // R3: read port after activity
        chk("R3 rdata zero after writes", int'(upd_rdata), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule